// File: doc/BRIEF.md
# Output Compare Timer with Master Override

This block is an eight-channel output compare unit. A 16-bit up-counter advances at the clock rate divided by a selectable power of two. Each channel holds a 16-bit compare value. When the counter reaches that value, the channel raises a flag and changes its pin according to a 2-bit action code. Software can also fire a channel's action at any time through a strobe. Such a strobe changes the pin but leaves the flag untouched.

Channel 7 is the master channel. When it matches, or when it is strobed, it writes a data byte onto every pin selected by a mask byte, and that write beats whatever the pin's own channel does in the same cycle. The same channel can also restart the counter, which gives a programmable period. That makes the block usable as a multi-output PWM generator. A per-channel option toggles a pin each time the counter wraps.

The host reaches the block through a simple write strobe and a combinational read port.

Top module: `oc_timer`

Register addresses (5-bit):

| Address | Contents |
|---------|----------|
| 0 | Control: bit0 run, bit1 fast clear, bit2 restart-on-master, bit3 overflow interrupt enable, bits6:4 prescale code |
| 1 | Per-channel output compare select |
| 2 | Action codes, two bits per channel, channel i in bits 2i+1:2i |
| 3 | Per-channel interrupt enable |
| 4 | Flags: bits7:0 channel flags, bit8 overflow flag |
| 5 | Strobe register, write only |
| 6 | Master register: bits7:0 mask, bits15:8 levels |
| 7 | Per-channel toggle-on-wrap enables |
| 8 to 15 | Compare values of channels 0 to 7 |
| 16 | Counter, read only |

## Requirements
- R1: The counter advances once every 2^k clocks, where k is the prescale code in control bits 6:4. It holds its value while control bit 0 (run) is 0.
- R2: When the counter steps from FFFF to 0000, the overflow flag (address 4, bit 8) is set. Writing 1 to that bit clears it. `ovf_irq` equals the flag ANDed with control bit 3.
- R3: When control bit 2 is set and the counter steps while it equals channel 7's compare value, the counter returns to 0000 instead of incrementing.
- R4: On a match, a selected channel applies its action code to its pin: 00 leaves the pin alone, 01 toggles it, 10 drives it low and 11 drives it high. The match also sets that channel's flag.
- R5: A match acts only in the first clock cycle of a counter value. A value held for many clocks by the prescaler sets the flag and acts on the pin once.
- R6: On a channel 7 match, every selected pin whose mask bit is 1 takes its level bit. This master write overrides the pin's own channel action in the same cycle.
- R7: Writing 1 to bit i of address 5 applies channel i's action at once without setting any flag. Strobing channel 7 applies the master mask-and-level write.
- R8: When a pin's bit in address 7 is 1 and its channel is selected for output compare, the pin toggles on each counter wrap. A pin whose channel is not selected is unaffected.
- R9: After reset, all registers, flags, the counter and the pins are 0. `pin_oe[i]` is 1 only for a selected channel that has a nonzero action code, a master mask bit or a wrap-toggle bit.
- R10: With control bit 1 set, writing a channel's compare register clears that channel's flag. With the bit clear, the write leaves the flag as it is.
- R11: When a wrap toggle and a compare action hit the same pin in the same cycle, the compare action wins.
- R12: Writing 1 to a bit of address 4 clears that flag, and bits written 0 are left alone. `ch_irq` equals the flags ANDed with the address 3 enables.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 5 | Write address |
| wr_data | input | 16 | Write data |
| rd_addr | input | 5 | Read address |
| rd_data | output | 16 | Read data (combinational) |
| pin_out | output | 8 | Pin levels |
| pin_oe | output | 8 | Pin output enables |
| flags | output | 8 | Channel flags |
| ch_irq | output | 8 | Channel interrupt requests |
| ovf_flag | output | 1 | Counter wrap flag |
| ovf_irq | output | 1 | Wrap interrupt request |

## Verification
The assertions assume that a strobe and a master match never drive conflicting pin updates in an unexpected order. They also assume that channel 7's compare value stays fixed while the counter sits on it with restart enabled. The stimulus keeps to this by changing master and compare settings only when those values lie away from the current counter value.

All compare values are placed a fixed margin ahead of a counter value read just before the write. This keeps every match in the future and avoids races with the write itself. Before the long wait for a counter wrap, every action code except the one under test is set to zero. The matches that occur along the way therefore leave the pins unchanged.

// File: rtl/oc_timer_pkg.sv
package oc_timer_pkg;

  localparam int A_CTRL  = 0;
  localparam int A_SEL   = 1;
  localparam int A_ACT   = 2;
  localparam int A_IE    = 3;
  localparam int A_FLAG  = 4;
  localparam int A_FORCE = 5;
  localparam int A_MSTR  = 6;
  localparam int A_TOV   = 7;
  localparam int A_CMP0  = 8;
  localparam int A_CNT   = 16;

  typedef enum logic [1:0] {
    ACT_NONE   = 2'b00,
    ACT_TOGGLE = 2'b01,
    ACT_LOW    = 2'b10,
    ACT_HIGH   = 2'b11
  } pin_act_e;

  // pin level after an action code is applied to the present level
  function automatic logic act_level(input logic [1:0] code, input logic cur);
    case (pin_act_e'(code))
      ACT_TOGGLE: return ~cur;
      ACT_LOW:    return 1'b0;
      ACT_HIGH:   return 1'b1;
      default:    return cur;
    endcase
  endfunction

endpackage

// File: rtl/oc_timer_base.sv
module oc_timer_base #(
  parameter int CNT_W = 16,
  parameter int PS_W  = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic [PS_W-1:0]  ps_sel,
  input  logic             clr_req,
  output logic [CNT_W-1:0] cnt,
  output logic             tick,
  output logic             fresh,
  output logic             ovf_evt
);
  localparam int PH_W = (1 << PS_W) - 1;

  logic [PH_W-1:0] phase;

  // true when the low `sel` phase bits are all ones
  function automatic logic phase_done(input logic [PH_W-1:0] ph,
                                      input logic [PS_W-1:0] sel);
    logic [PH_W:0] m;
    m = (PH_W+1)'(1) << sel;
    m = m - (PH_W+1)'(1);
    return (ph & m[PH_W-1:0]) == m[PH_W-1:0];
  endfunction

  assign tick    = run && phase_done(phase, ps_sel);
  assign ovf_evt = tick && (&cnt);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase <= '0;
      cnt   <= '0;
      fresh <= 1'b0;
    end else begin
      if (run) phase <= phase + 1'b1;
      if (tick) cnt <= clr_req ? '0 : cnt + 1'b1;
      fresh <= tick;
    end
  end
endmodule

// File: rtl/oc_timer_chan.sv
module oc_timer_chan import oc_timer_pkg::*; #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             sel,
  input  logic [1:0]       act,
  input  logic             tov,
  input  logic [CNT_W-1:0] cnt,
  input  logic [CNT_W-1:0] cmp,
  input  logic             fresh,
  input  logic             ovf_evt,
  input  logic             force_hit,
  input  logic             master_evt,
  input  logic             m_mask,
  input  logic             m_data,
  output logic             match,
  output logic             pin,
  output logic             oe
);
  logic pin_nxt;

  assign match = sel && fresh && (cnt == cmp);
  assign oe    = sel && ((act != 2'b00) || m_mask || tov);

  // priority: master write, own compare or strobe, wrap toggle
  always_comb begin
    pin_nxt = pin;
    if (sel) begin
      if (master_evt && m_mask)   pin_nxt = m_data;
      else if (match || force_hit) pin_nxt = act_level(act, pin);
      else if (tov && ovf_evt)    pin_nxt = ~pin;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pin <= 1'b0;
    else        pin <= pin_nxt;
  end
endmodule

// File: rtl/oc_timer.sv
module oc_timer import oc_timer_pkg::*; #(
  parameter int NCH    = 8,
  parameter int CNT_W  = 16,
  parameter int PS_W   = 3,
  parameter int ADDR_W = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [CNT_W-1:0]  wr_data,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [CNT_W-1:0]  rd_data,
  output logic [NCH-1:0]    pin_out,
  output logic [NCH-1:0]    pin_oe,
  output logic [NCH-1:0]    flags,
  output logic [NCH-1:0]    ch_irq,
  output logic              ovf_flag,
  output logic              ovf_irq
);
  localparam int MSTR  = NCH - 1;
  localparam int ACT_W = 2 * NCH;
  localparam int PS_LO = 4;

  logic              run_q, fast_q, rst_opt_q, ovf_ie_q;
  logic [PS_W-1:0]   ps_q;
  logic [NCH-1:0]    sel_q, ie_q, mmask_q, mdata_q, tov_q, flag_q;
  logic [ACT_W-1:0]  act_q;
  logic              ovf_q;
  logic [CNT_W-1:0]  cmp_q [NCH];

  logic [CNT_W-1:0]  cnt;
  logic              tick, fresh, ovf_evt, clr_req;
  logic [NCH-1:0]    match_vec, force_vec, cmp_wr, pin_q, oe_vec;
  logic              master_evt;

  wire hit_ctrl = wr_en && (wr_addr == ADDR_W'(A_CTRL));
  wire hit_flag = wr_en && (wr_addr == ADDR_W'(A_FLAG));

  assign force_vec  = (wr_en && wr_addr == ADDR_W'(A_FORCE)) ? wr_data[NCH-1:0] : '0;
  assign master_evt = match_vec[MSTR] || (force_vec[MSTR] && sel_q[MSTR]);
  assign clr_req    = rst_opt_q && (cnt == cmp_q[MSTR]);

  oc_timer_base #(.CNT_W(CNT_W), .PS_W(PS_W)) u_base (
    .clk(clk), .rst_n(rst_n), .run(run_q), .ps_sel(ps_q), .clr_req(clr_req),
    .cnt(cnt), .tick(tick), .fresh(fresh), .ovf_evt(ovf_evt)
  );

  for (genvar g = 0; g < NCH; g++) begin : g_ch
    assign cmp_wr[g] = wr_en && (wr_addr == ADDR_W'(A_CMP0 + g));

    oc_timer_chan #(.CNT_W(CNT_W)) u_chan (
      .clk(clk), .rst_n(rst_n), .sel(sel_q[g]), .act(act_q[2*g +: 2]),
      .tov(tov_q[g]), .cnt(cnt), .cmp(cmp_q[g]), .fresh(fresh),
      .ovf_evt(ovf_evt), .force_hit(force_vec[g]), .master_evt(master_evt),
      .m_mask(mmask_q[g]), .m_data(mdata_q[g]), .match(match_vec[g]),
      .pin(pin_q[g]), .oe(oe_vec[g])
    );

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        cmp_q[g]  <= '0;
        flag_q[g] <= 1'b0;
      end else begin
        if (cmp_wr[g]) cmp_q[g] <= wr_data;
        if (match_vec[g])
          flag_q[g] <= 1'b1;
        else if ((hit_flag && wr_data[g]) || (fast_q && cmp_wr[g]))
          flag_q[g] <= 1'b0;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q <= 1'b0; fast_q <= 1'b0; rst_opt_q <= 1'b0; ovf_ie_q <= 1'b0;
      ps_q <= '0; sel_q <= '0; act_q <= '0; ie_q <= '0;
      mmask_q <= '0; mdata_q <= '0; tov_q <= '0; ovf_q <= 1'b0;
    end else begin
      if (hit_ctrl) begin
        run_q     <= wr_data[0];
        fast_q    <= wr_data[1];
        rst_opt_q <= wr_data[2];
        ovf_ie_q  <= wr_data[3];
        ps_q      <= wr_data[PS_LO +: PS_W];
      end
      if (wr_en && wr_addr == ADDR_W'(A_SEL)) sel_q <= wr_data[NCH-1:0];
      if (wr_en && wr_addr == ADDR_W'(A_ACT)) act_q <= wr_data[ACT_W-1:0];
      if (wr_en && wr_addr == ADDR_W'(A_IE))  ie_q  <= wr_data[NCH-1:0];
      if (wr_en && wr_addr == ADDR_W'(A_TOV)) tov_q <= wr_data[NCH-1:0];
      if (wr_en && wr_addr == ADDR_W'(A_MSTR)) begin
        mmask_q <= wr_data[NCH-1:0];
        mdata_q <= wr_data[2*NCH-1:NCH];
      end
      if (ovf_evt)                      ovf_q <= 1'b1;
      else if (hit_flag && wr_data[NCH]) ovf_q <= 1'b0;
    end
  end

  always_comb begin
    rd_data = '0;
    case (rd_addr)
      ADDR_W'(A_CTRL): rd_data = CNT_W'({ps_q, ovf_ie_q, rst_opt_q, fast_q, run_q});
      ADDR_W'(A_SEL):  rd_data = CNT_W'(sel_q);
      ADDR_W'(A_ACT):  rd_data = CNT_W'(act_q);
      ADDR_W'(A_IE):   rd_data = CNT_W'(ie_q);
      ADDR_W'(A_FLAG): rd_data = CNT_W'({ovf_q, flag_q});
      ADDR_W'(A_MSTR): rd_data = CNT_W'({mdata_q, mmask_q});
      ADDR_W'(A_TOV):  rd_data = CNT_W'(tov_q);
      ADDR_W'(A_CNT):  rd_data = cnt;
      default: begin
        for (int i = 0; i < NCH; i++)
          if (rd_addr == ADDR_W'(A_CMP0 + i)) rd_data = cmp_q[i];
      end
    endcase
  end

  assign pin_out  = pin_q;
  assign pin_oe   = oe_vec;
  assign flags    = flag_q;
  assign ch_irq   = flag_q & ie_q;
  assign ovf_flag = ovf_q;
  assign ovf_irq  = ovf_q & ovf_ie_q;
endmodule

// File: rtl/oc_timer_chk.sv
module oc_timer_chk #(
  parameter int NCH   = 8,
  parameter int CNT_W = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic             run,
  input logic             rst_opt,
  input logic             tick,
  input logic [CNT_W-1:0] cnt,
  input logic [CNT_W-1:0] cmp_m,
  input logic [NCH-1:0]   match_vec,
  input logic             master_evt,
  input logic [NCH-1:0]   m_mask,
  input logic [NCH-1:0]   m_data,
  input logic [NCH-1:0]   sel,
  input logic [NCH-1:0]   pin,
  input logic [NCH-1:0]   oe,
  input logic [NCH-1:0]   flags,
  input logic             ovf_flag
);
  assert_halt_hold_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !run |=> $stable(cnt));

  assert_count_step_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt != $past(cnt)) |-> ((cnt == $past(cnt) + 1'b1) || (cnt == '0)));

  assert_wrap_flag_R2: assert property (@(posedge clk) disable iff (!rst_n)
    ((cnt == '0) && ($past(cnt) == '1)) |-> ovf_flag);

  assert_master_restart_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (rst_opt && tick && (cnt == cmp_m)) |=> (cnt == '0));

  assert_master_wins_R6: assert property (@(posedge clk) disable iff (!rst_n)
    master_evt |=> (((pin ^ $past(m_data)) & $past(m_mask & sel)) == '0));

  assert_flag_source_R7: assert property (@(posedge clk) disable iff (!rst_n)
    ((flags & ~$past(flags) & ~$past(match_vec)) == '0));

  assert_oe_gated_R9: assert property (@(posedge clk) disable iff (!rst_n)
    ((oe & ~sel) == '0));
endmodule

bind oc_timer oc_timer_chk #(.NCH(NCH), .CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .run(run_q), .rst_opt(rst_opt_q), .tick(tick),
  .cnt(cnt), .cmp_m(cmp_q[MSTR]), .match_vec(match_vec), .master_evt(master_evt),
  .m_mask(mmask_q), .m_data(mdata_q), .sel(sel_q), .pin(pin_q), .oe(oe_vec),
  .flags(flag_q), .ovf_flag(ovf_q)
);

// File: tb/tb_oc_timer.sv
module tb_oc_timer;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [4:0]  wr_addr = '0;
  logic [15:0] wr_data = '0;
  logic [4:0]  rd_addr = '0;
  logic [15:0] rd_data;
  logic [7:0]  pin_out, pin_oe, flags, ch_irq;
  logic        ovf_flag, ovf_irq;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #2 clk = ~clk;

  oc_timer dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_addr(rd_addr), .rd_data(rd_data), .pin_out(pin_out), .pin_oe(pin_oe),
    .flags(flags), .ch_irq(ch_irq), .ovf_flag(ovf_flag), .ovf_irq(ovf_irq)
  );

  function automatic logic [15:0] ctl(input bit run, input bit fast, input bit rst,
                                      input bit ie, input int ps);
    return {9'd0, 3'(ps), ie, rst, fast, run};
  endfunction

  task automatic check(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic wr(input int a, input logic [15:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = 5'(a); wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input int a, output logic [15:0] v);
    rd_addr = 5'(a);
    #1 v = rd_data;
  endtask

  task automatic wait_bit(input int idx, input int limit, output bit seen);
    seen = 1'b0;
    for (int k = 0; k < limit; k++) begin
      @(negedge clk);
      if (flags[idx]) begin seen = 1'b1; break; end
    end
  endtask

  task automatic t_reset;
    logic [15:0] v;
    rd(0, v);  check("R9", "control after reset", v, 0);
    rd(16, v); check("R9", "counter after reset", v, 0);
    check("R9", "pins after reset", {pin_out, pin_oe, flags, ch_irq}, 0);
    check("R9", "overflow flag after reset", ovf_flag, 0);
    repeat (10) @(negedge clk);
    rd(16, v); check("R1", "counter idle while run is 0", v, 0);
  endtask

  task automatic t_prescale;
    logic [15:0] a, b;
    wr(0, ctl(1, 0, 0, 0, 0));
    rd(16, a); repeat (40) @(negedge clk); rd(16, b);
    check("R1", "divide by 1 steps in 40 clocks", 16'(b - a), 40);
    wr(0, ctl(1, 0, 0, 0, 3));
    repeat (3) @(negedge clk);
    rd(16, a); repeat (80) @(negedge clk); rd(16, b);
    check("R1", "divide by 8 steps in 80 clocks", 16'(b - a), 10);
    wr(0, ctl(0, 0, 0, 0, 0));
    rd(16, a); repeat (20) @(negedge clk); rd(16, b);
    check("R1", "counter holds when stopped", b, a);
    wr(0, ctl(1, 0, 0, 0, 0));
  endtask

  task automatic t_actions;
    logic [15:0] c;
    bit seen;
    wr(1, 16'h00FF);
    check("R9", "no enable without a pin function", pin_oe, 0);
    wr(2, 16'h003D);
    check("R9", "enables follow action codes", pin_oe, 8'h07);
    wr(5, 16'h0002);
    check("R7", "strobe drives pin 1 high", pin_out[1], 1);
    check("R7", "strobe sets no flag", flags, 0);
    wr(2, 16'h0039);
    rd(16, c);
    wr(8, c + 16'd20); wr(9, c + 16'd20); wr(10, c + 16'd20);
    wait_bit(0, 100, seen);
    check("R4", "match seen on channel 0", seen, 1);
    check("R4", "flags of channels 0-2", flags[2:0], 3'b111);
    check("R4", "toggle, low, high results", pin_out[2:0], 3'b101);
  endtask

  task automatic t_first_cycle;
    logic [15:0] c;
    bit seen;
    wr(4, 16'h00FF);
    wr(2, 16'h0079);
    wr(0, ctl(1, 0, 0, 0, 7));
    rd(16, c);
    wr(11, c + 16'd2);
    wait_bit(3, 600, seen);
    check("R5", "slow match seen on channel 3", seen, 1);
    wr(4, 16'h0008);
    check("R12", "flag 3 cleared by writing 1", flags[3], 0);
    repeat (200) @(negedge clk);
    check("R5", "no second flag on held value", flags[3], 0);
    check("R5", "pin 3 toggled exactly once", pin_out[3], 1);
    wr(0, ctl(1, 0, 0, 0, 0));
  endtask

  task automatic t_master;
    logic [15:0] c;
    bit seen;
    wr(2, 16'h0279);
    wr(6, 16'h1010);
    rd(16, c);
    wr(12, c + 16'd20); wr(15, c + 16'd20);
    wait_bit(7, 100, seen);
    check("R6", "master match seen", seen, 1);
    check("R6", "master level beats drive-low on pin 4", pin_out[4], 1);
    check("R6", "channel 4 flag set", flags[4], 1);
    wr(4, 16'h0080);
    check("R12", "writing 1 clears only flag 7", flags[7:4], 4'b0001);
  endtask

  task automatic t_force;
    wr(4, 16'h00FF);
    wr(2, 16'h0E79);
    wr(5, 16'h0020);
    check("R7", "strobe drives pin 5 high", pin_out[5], 1);
    wr(5, 16'h0001);
    check("R7", "strobe toggles pin 0", pin_out[0], 0);
    wr(6, 16'h0121);
    wr(5, 16'h0080);
    check("R7", "master strobe writes pins", pin_out, 8'h1D);
    check("R7", "strobes leave flags clear", flags, 0);
  endtask

  task automatic t_fast;
    logic [15:0] c;
    bit seen;
    rd(16, c);
    wr(14, c + 16'd15);
    wait_bit(6, 100, seen);
    check("R10", "channel 6 match seen", seen, 1);
    wr(14, c + 16'd15);
    check("R10", "flag kept without fast clear", flags[6], 1);
    wr(3, 16'h0040);
    check("R12", "interrupt follows flag and enable", ch_irq, 8'h40);
    wr(0, ctl(1, 1, 0, 0, 0));
    wr(14, c + 16'd15);
    check("R10", "compare write clears flag in fast mode", flags[6], 0);
    check("R12", "interrupt drops with flag", ch_irq, 0);
    wr(0, ctl(1, 0, 0, 0, 0));
  endtask

  task automatic t_restart;
    logic [15:0] c, p, v, mx;
    bit seen, zero;
    wr(6, 16'h0000);
    wr(4, 16'h00FF);
    wr(0, ctl(1, 0, 1, 0, 0));
    rd(16, c);
    p = c + 16'd40;
    wr(15, p);
    wait_bit(7, 100, seen);
    check("R3", "master match seen", seen, 1);
    mx = '0; zero = 1'b0;
    for (int k = 0; k < 300; k++) begin
      @(negedge clk);
      rd(16, v);
      if (v > mx) mx = v;
      if (v == 0) zero = 1'b1;
    end
    check("R3", "counter peaks at master value", mx, p);
    check("R3", "counter returns to zero", zero, 1);
    wr(0, ctl(1, 0, 0, 0, 0));
  endtask

  task automatic t_overflow;
    bit seen;
    wr(2, 16'h00C0);
    wr(1, 16'h00FD);
    wr(7, 16'h000E);
    wr(11, 16'hFFFF);
    wr(4, 16'h00FF);
    wr(0, ctl(1, 0, 0, 1, 0));
    check("R9", "enables for wrap toggles and actions", pin_oe, 8'h0C);
    seen = 1'b0;
    for (int k = 0; k < 70000; k++) begin
      @(negedge clk);
      if (ovf_flag) begin seen = 1'b1; break; end
    end
    check("R2", "wrap sets overflow flag", seen, 1);
    check("R2", "overflow interrupt raised", ovf_irq, 1);
    check("R8", "pin 2 toggled on wrap", pin_out[2], 0);
    check("R8", "unselected pin 1 unchanged", pin_out[1], 0);
    check("R11", "compare high beats wrap toggle on pin 3", pin_out[3], 1);
    wr(4, 16'h0100);
    check("R2", "overflow flag cleared by writing 1", {ovf_flag, ovf_irq}, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset;
    t_prescale;
    t_actions;
    t_first_cycle;
    t_master;
    t_force;
    t_fast;
    t_restart;
    t_overflow;
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual running expected finished");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule